// File: doc/BRIEF.md
# Configuration Start-Up Sequencer

This block orders the power-up, configuration and start-up events of a programmable device. It watches three supply-good inputs, a configuration-memory-cleared indication and a configuration-load-complete indication. From them it drives a global reset net, a global tristate net, a global write-enable net and an init-done flag. It also latches the three mode-select pins at the moment initialization finishes.

For every I/O pad it produces a 2-bit mode code. Before start-up, each pad's driver is off, and a pull-up is applied or not according to an active-low pull select input. In a real device that input is weakly held high when left unconnected, so it floats by default. After start-up, used pads pass to user control. Unused pads take a programmable termination.

There is no data stream. Every pin is a plain level control or status signal. All phase outputs come from registers.

Top module: `cfg_startup_seq`

## Requirements
- R1: `por_active` is high at once (asynchronously) whenever any of the three supply-good inputs is low. It falls on the second rising clock edge after all three are high.
- R2: While `por_active` is high, `glob_reset` and `glob_tristate` are high, and `glob_wr_en`, `init_done` and `mode_valid` are low.
- R3: Until `glob_tristate` falls, every pad code is pull-up (1) when `pull_cfg_n` is low and float (0) when it is high. No pad shows the user code (3).
- R4: The sequencer leaves power-up one edge after `por_active` falls. It then waits for `mem_clear_done`. `init_done` rises on the first edge that samples `mem_clear_done` high, and not before.
- R5: On that same edge, `mode_pins` is captured into `mode_latched` and `mode_valid` goes high. Both then stay fixed, whatever the pins do, until the next power-on reset.
- R6: `glob_reset` stays high through configuration. It falls on the first edge that samples `cfg_load_done` high while `init_done` is high, and `glob_tristate` stays high on that edge.
- R7: `glob_tristate` falls one edge after `glob_reset` falls. From then on, a pad whose `pad_used` bit is set shows code 3 (user). An unused pad shows the code set by `unused_term`: 00 gives pull-down (2), 01 gives pull-up (1), and 1x gives float (0).
- R8: `glob_wr_en` rises exactly GWE_DELAY edges after `glob_tristate` falls (default 1), and stays high in user mode. It is never high while `glob_tristate` is high.
- R9: Dropping any supply-good input at any phase returns `glob_reset`=1, `glob_tristate`=1, `glob_wr_en`=0, `init_done`=0 and `mode_valid`=0 without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| bank_pwr_ok | input | 1 | I/O bank supply good |
| core_pwr_ok | input | 1 | Core supply good |
| aux_pwr_ok | input | 1 | Auxiliary supply good |
| mem_clear_done | input | 1 | Configuration memory initialization finished |
| cfg_load_done | input | 1 | Configuration data fully loaded |
| pull_cfg_n | input | 1 | Low: pull-ups on all pads before start-up |
| mode_pins | input | 3 | Configuration mode select pins |
| unused_term | input | 2 | Termination for unused pads after start-up |
| pad_used | input | NPAD | Per-pad flag: pad is used by the design |
| por_active | output | 1 | Power-on reset held |
| glob_reset | output | 1 | Global set/reset, active high |
| glob_tristate | output | 1 | Global tristate, high keeps drivers off |
| glob_wr_en | output | 1 | Global write enable for memories and registers |
| init_done | output | 1 | Initialization complete flag |
| mode_latched | output | 3 | Captured mode pins |
| mode_valid | output | 1 | `mode_latched` holds a captured value |
| pad_mode | output | 2*NPAD | Per-pad code: 0 float, 1 pull-up, 2 pull-down, 3 user |

## Verification
The assertions assume that `mem_clear_done` and `cfg_load_done` are synchronous to `clk`. They also assume that the supply-good inputs change only between clock edges. Under those assumptions, the only asynchronous event is the reset path. The stimulus drives every input one time unit after a rising edge. It removes a supply only at such points, so reset assertion never collides with a sampling edge.

// File: rtl/startup_pkg.sv
package startup_pkg;
  typedef enum logic [2:0] {
    PH_POWER_UP   = 3'd0,
    PH_INIT_MEM   = 3'd1,
    PH_CONFIG     = 3'd2,
    PH_REL_RESET  = 3'd3,
    PH_REL_TRI    = 3'd4,
    PH_REL_WREN   = 3'd5,
    PH_USER       = 3'd6
  } phase_t;

  typedef enum logic [1:0] {
    PAD_FLOAT     = 2'd0,
    PAD_PULL_UP   = 2'd1,
    PAD_PULL_DOWN = 2'd2,
    PAD_USER      = 2'd3
  } pad_code_t;
endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic bank_ok,
  input  logic core_ok,
  input  logic aux_ok,
  output logic rst_n,
  output logic por_active
);
  logic supplies_ok;
  logic [STAGES-1:0] shift_q;

  assign supplies_ok = bank_ok & core_ok & aux_ok;

  always_ff @(posedge clk or negedge supplies_ok) begin
    if (!supplies_ok) shift_q <= '0;
    else              shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_n      = shift_q[STAGES-1];
  assign por_active = ~shift_q[STAGES-1];

  // R1
  release_after_ok_chk: assert property (@(posedge clk) disable iff (!supplies_ok)
    $rose(rst_n) |-> $past(supplies_ok));
endmodule

// File: rtl/startup_fsm.sv
module startup_fsm
  import startup_pkg::*;
#(
  parameter int GWE_DELAY = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mem_clear_done,
  input  logic       cfg_load_done,
  input  logic [2:0] mode_pins,
  output logic       glob_reset,
  output logic       glob_tristate,
  output logic       glob_wr_en,
  output logic       init_done,
  output logic [2:0] mode_latched,
  output logic       mode_valid
);
  localparam int CNT_W = (GWE_DELAY > 1) ? $clog2(GWE_DELAY) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GWE_DELAY - 1);

  phase_t phase_q, phase_nxt;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    phase_nxt = phase_q;
    unique case (phase_q)
      PH_POWER_UP:  phase_nxt = PH_INIT_MEM;
      PH_INIT_MEM:  if (mem_clear_done) phase_nxt = PH_CONFIG;
      PH_CONFIG:    if (cfg_load_done)  phase_nxt = PH_REL_RESET;
      PH_REL_RESET: phase_nxt = PH_REL_TRI;
      PH_REL_TRI:   if (cnt_q == CNT_LAST) phase_nxt = PH_REL_WREN;
      PH_REL_WREN:  phase_nxt = PH_USER;
      PH_USER:      phase_nxt = PH_USER;
      default:      phase_nxt = PH_POWER_UP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q       <= PH_POWER_UP;
      cnt_q         <= '0;
      glob_reset    <= 1'b1;
      glob_tristate <= 1'b1;
      glob_wr_en    <= 1'b0;
      init_done     <= 1'b0;
      mode_latched  <= '0;
      mode_valid    <= 1'b0;
    end else begin
      phase_q       <= phase_nxt;
      cnt_q         <= (phase_q == PH_REL_TRI) ? cnt_q + 1'b1 : '0;
      glob_reset    <= (phase_nxt inside {PH_POWER_UP, PH_INIT_MEM, PH_CONFIG});
      glob_tristate <= !(phase_nxt inside {PH_REL_TRI, PH_REL_WREN, PH_USER});
      glob_wr_en    <= (phase_nxt inside {PH_REL_WREN, PH_USER});
      init_done     <= !(phase_nxt inside {PH_POWER_UP, PH_INIT_MEM});
      if (phase_q == PH_INIT_MEM && mem_clear_done) begin
        mode_latched <= mode_pins;
        mode_valid   <= 1'b1;
      end
    end
  end

  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |=> (mode_valid && $stable(mode_latched)));
  // R5
  init_has_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> mode_valid);
  // R7
  tri_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_tristate |-> !glob_reset);
  // R8
  wren_needs_tri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glob_wr_en |-> !glob_tristate);
  // R8
  wren_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(glob_wr_en) |-> $past(!glob_tristate));
  // R6
  reset_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(glob_reset) |-> glob_tristate);
endmodule

// File: rtl/pad_pull_ctrl.sv
module pad_pull_ctrl
  import startup_pkg::*;
#(
  parameter int NPAD = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            glob_tristate,
  input  logic            pull_cfg_n,
  input  logic [1:0]      unused_term,
  input  logic [NPAD-1:0] pad_used,
  output logic [2*NPAD-1:0] pad_mode
);
  pad_code_t term_code;

  always_comb begin
    unique case (unused_term)
      2'b00:   term_code = PAD_PULL_DOWN;
      2'b01:   term_code = PAD_PULL_UP;
      default: term_code = PAD_FLOAT;
    endcase
  end

  for (genvar i = 0; i < NPAD; i++) begin : g_pad
    pad_code_t code;
    always_comb begin
      if (glob_tristate) code = pull_cfg_n ? PAD_FLOAT : PAD_PULL_UP;
      else if (pad_used[i]) code = PAD_USER;
      else code = term_code;
    end
    assign pad_mode[2*i +: 2] = code;

    // R3
    no_user_in_tri_chk: assert property (@(posedge clk) disable iff (!rst_n)
      glob_tristate |-> (pad_mode[2*i +: 2] != 2'd3));
  end
endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq #(
  parameter int NPAD      = 4,
  parameter int GWE_DELAY = 1
) (
  input  logic              clk,
  input  logic              bank_pwr_ok,
  input  logic              core_pwr_ok,
  input  logic              aux_pwr_ok,
  input  logic              mem_clear_done,
  input  logic              cfg_load_done,
  input  logic              pull_cfg_n,
  input  logic [2:0]        mode_pins,
  input  logic [1:0]        unused_term,
  input  logic [NPAD-1:0]   pad_used,
  output logic              por_active,
  output logic              glob_reset,
  output logic              glob_tristate,
  output logic              glob_wr_en,
  output logic              init_done,
  output logic [2:0]        mode_latched,
  output logic              mode_valid,
  output logic [2*NPAD-1:0] pad_mode
);
  logic rst_n;

  por_sync #(.STAGES(2)) u_por (
    .clk(clk), .bank_ok(bank_pwr_ok), .core_ok(core_pwr_ok), .aux_ok(aux_pwr_ok),
    .rst_n(rst_n), .por_active(por_active)
  );

  startup_fsm #(.GWE_DELAY(GWE_DELAY)) u_fsm (
    .clk(clk), .rst_n(rst_n), .mem_clear_done(mem_clear_done),
    .cfg_load_done(cfg_load_done), .mode_pins(mode_pins),
    .glob_reset(glob_reset), .glob_tristate(glob_tristate), .glob_wr_en(glob_wr_en),
    .init_done(init_done), .mode_latched(mode_latched), .mode_valid(mode_valid)
  );

  pad_pull_ctrl #(.NPAD(NPAD)) u_pad (
    .clk(clk), .rst_n(rst_n), .glob_tristate(glob_tristate), .pull_cfg_n(pull_cfg_n),
    .unused_term(unused_term), .pad_used(pad_used), .pad_mode(pad_mode)
  );
endmodule

// File: tb/cfg_startup_seq_tb.sv
module cfg_startup_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPAD = 4;
  localparam int DLY  = 2;

  logic clk = 1'b0;
  logic bank_ok = 0, core_ok = 0, aux_ok = 0;
  logic mem_clr = 0, cfg_done = 0, pull_n = 1;
  logic [2:0] mode_pins = '0;
  logic [1:0] term = '0;
  logic [NPAD-1:0] used = '0;
  logic por_active, g_reset, g_tri, g_wren, init_done, mode_valid;
  logic [2:0] mode_lat;
  logic [2*NPAD-1:0] pad_mode;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_startup_seq #(.NPAD(NPAD), .GWE_DELAY(DLY)) u_dut (
    .clk(clk), .bank_pwr_ok(bank_ok), .core_pwr_ok(core_ok), .aux_pwr_ok(aux_ok),
    .mem_clear_done(mem_clr), .cfg_load_done(cfg_done), .pull_cfg_n(pull_n),
    .mode_pins(mode_pins), .unused_term(term), .pad_used(used),
    .por_active(por_active), .glob_reset(g_reset), .glob_tristate(g_tri),
    .glob_wr_en(g_wren), .init_done(init_done), .mode_latched(mode_lat),
    .mode_valid(mode_valid), .pad_mode(pad_mode)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [2*NPAD-1:0] cfg_pads(logic pn);
    logic [2*NPAD-1:0] v;
    for (int i = 0; i < NPAD; i++) v[2*i +: 2] = pn ? 2'd0 : 2'd1;
    return v;
  endfunction

  function automatic logic [2*NPAD-1:0] user_pads(logic [NPAD-1:0] u, logic [1:0] t);
    logic [2*NPAD-1:0] v;
    for (int i = 0; i < NPAD; i++)
      v[2*i +: 2] = u[i] ? 2'd3 : (t == 2'b00 ? 2'd2 : (t == 2'b01 ? 2'd1 : 2'd0));
    return v;
  endfunction

  initial begin
    tick();
    for (int it = 0; it < 64; it++) begin
      logic [2:0] m;
      m = it[2:0];
      pull_n = it[3];
      term = it[5:4];
      used = 4'(it * 5 + 3);
      mode_pins = '0; mem_clr = 0; cfg_done = 0;
      tick(); tick();
      // R2 reset state
      chk("R1 por held", {31'd0, por_active}, 1);
      chk("R2 outputs in reset", {28'd0, g_reset, g_tri, g_wren, init_done}, 32'b1100);
      chk("R2 mode_valid in reset", {31'd0, mode_valid}, 0);
      chk("R3 pads in reset", pad_mode, cfg_pads(pull_n));
      bank_ok = 1; core_ok = 1; aux_ok = 1;
      tick();
      chk("R1 por after 1 edge", {31'd0, por_active}, 1);
      tick();
      chk("R1 por after 2 edges", {31'd0, por_active}, 0);
      tick(); tick();
      chk("R4 init_done waits", {31'd0, init_done}, 0);
      chk("R6 reset during init", {31'd0, g_reset}, 1);
      mode_pins = m; mem_clr = 1;
      tick();
      chk("R4 init_done rise", {31'd0, init_done}, 1);
      chk("R5 mode captured", {28'd0, mode_valid, mode_lat}, {28'd0, 1'b1, m});
      mode_pins = ~m; mem_clr = 0;
      tick();
      chk("R5 mode held", {28'd0, mode_valid, mode_lat}, {28'd0, 1'b1, m});
      chk("R6 reset held in config", {31'd0, g_reset}, 1);
      cfg_done = 1;
      tick();
      chk("R6 reset released", {30'd0, g_reset, g_tri}, 32'b01);
      chk("R3 pads before startup", pad_mode, cfg_pads(pull_n));
      tick();
      chk("R7 tristate released", {30'd0, g_tri, g_wren}, 0);
      chk("R7 pad termination", pad_mode, user_pads(used, term));
      for (int k = 1; k < DLY; k++) begin
        tick();
        chk("R8 wren still low", {31'd0, g_wren}, 0);
      end
      tick();
      chk("R8 wren released", {31'd0, g_wren}, 1);
      tick();
      chk("R8 wren held in user", {31'd0, g_wren}, 1);
      chk("R5 mode held in user", {29'd0, mode_lat}, {29'd0, m});
      case (it % 3)
        0: bank_ok = 0;
        1: core_ok = 0;
        default: aux_ok = 0;
      endcase
      #1;
      chk("R1 por async", {31'd0, por_active}, 1);
      chk("R9 async return", {27'd0, g_reset, g_tri, g_wren, init_done, mode_valid}, 32'b11000);
      bank_ok = 0; core_ok = 0; aux_ok = 0; cfg_done = 0;
      tick();
    end
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule